// File: doc/BRIEF.md
# GPIO Edge Interrupt Cause Unit

This block turns transitions on a GPIO port of up to 32 pins into one shared interrupt request. It watches the already-synchronised pin samples and compares each with the sample from the clock before. When a pin moves in a direction that its enables select, the pin's cause bit is set. A cause bit stays set until software clears it.

Each pin has a rising-edge enable and a falling-edge enable, and both may be set together. A separate per-pin event mask decides which causes reach the interrupt line. The line is level type: it stays high while any unmasked cause is pending. Software reads the pending causes with the mask already applied, then clears them by writing ones to the clear address. The usual pattern is to write back the value just read.

Register access uses a single-cycle write strobe and a combinational read port. The number of pins that are actually wired is set by a parameter. Bits above that count read as zero and never raise a cause. Only edge events exist. There is no level-sensitive mode.

Top module: `gpio_edge_cause_unit`

## Requirements
- R1: After reset, the rising enables, falling enables, event mask and all cause bits are 0, and `irq` is low.
- R2: A pin whose rising enable is 1 and whose sample goes from 0 to 1 between two consecutive clocks has its cause bit set at the second of those clocks.
- R3: A pin whose falling enable is 1 has its cause bit set on a 1-to-0 change. With both enables set, either direction sets the cause. With neither set, no change of the pin sets it.
- R4: Cause bits are sticky whatever the event mask holds. Setting a mask bit later exposes a cause that is already pending.
- R5: Reading address 3 returns the cause bits ANDed with the event mask.
- R6: A write to address 4 clears every cause bit whose data bit is 1. Data bits that are 0 leave their causes unchanged.
- R7: When an enabled edge and a clear for the same pin fall in the same cycle, the cause bit ends up set.
- R8: `irq` is high exactly while at least one cause bit has its event-mask bit set.
- R9: Pins at index PIN_COUNT and above never set a cause bit and never affect `irq`.
- R10: The register map is as follows. Address 0 is the rising enable, address 1 the falling enable and address 2 the event mask; all three can be written and read back. Address 4 reads as 0. Writes to address 3 and to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | PIN_W | Synchronised pin samples |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Write register address |
| wr_data | input | PIN_W | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | PIN_W | Combinational read data |
| irq | output | 1 | Shared level-type interrupt |

## Verification
The checker assumes that `pin_in` is already synchronous to `clk`. It also assumes that the pin history used for edge detection starts at 0 when reset is released, so a pin held high across reset counts as a rising edge on the first clock. It takes the register address encoding given in R10 as fixed. The bench changes pins and write strobes only on falling clock edges. Every transition therefore falls between two sampling edges and is seen exactly once. The bench opens each pin-edge scenario with the pins low, so the edges it produces are the only ones the checker can attribute.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      EVT_RISE_EN = 3'd0,
      EVT_FALL_EN = 3'd1,
      EVT_MASK    = 3'd2,
      EVT_PEND    = 3'd3,
      EVT_CLR     = 3'd4
   } evt_reg_e;
endpackage

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
   import gpio_evt_pkg::*;
#(
   parameter int PIN_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [PIN_W-1:0]  wr_data,
   output logic [PIN_W-1:0]  rise_en,
   output logic [PIN_W-1:0]  fall_en,
   output logic [PIN_W-1:0]  evt_mask,
   output logic [PIN_W-1:0]  clr_vec
);
   logic sel_rise, sel_fall, sel_mask, sel_clr;

   always_comb begin
      sel_rise = wr_en && (wr_addr == EVT_RISE_EN);
      sel_fall = wr_en && (wr_addr == EVT_FALL_EN);
      sel_mask = wr_en && (wr_addr == EVT_MASK);
      sel_clr  = wr_en && (wr_addr == EVT_CLR);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_en  <= '0;
         fall_en  <= '0;
         evt_mask <= '0;
      end else begin
         if (sel_rise) rise_en  <= wr_data;
         if (sel_fall) fall_en  <= wr_data;
         if (sel_mask) evt_mask <= wr_data;
      end
   end

   assign clr_vec = sel_clr ? wr_data : '0;
endmodule

// File: rtl/evt_edge_detect.sv
module evt_edge_detect #(
   parameter int PIN_W     = 32,
   parameter int PIN_COUNT = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIN_W-1:0] pin_in,
   input  logic [PIN_W-1:0] rise_en,
   input  logic [PIN_W-1:0] fall_en,
   output logic [PIN_W-1:0] hit
);
   for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      if (i < PIN_COUNT) begin : g_live
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= pin_in[i];
         end
         assign hit[i] = (rise_en[i] &  pin_in[i] & ~prev_q) |
                         (fall_en[i] & ~pin_in[i] &  prev_q);
      end else begin : g_dead
         assign hit[i] = 1'b0;
      end
   end
endmodule

// File: rtl/evt_cause_store.sv
module evt_cause_store #(
   parameter int PIN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIN_W-1:0] hit,
   input  logic [PIN_W-1:0] clr_vec,
   output logic [PIN_W-1:0] cause_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= (cause_q & ~clr_vec) | hit;
   end
endmodule

// File: rtl/gpio_edge_cause_unit.sv
module gpio_edge_cause_unit
   import gpio_evt_pkg::*;
#(
   parameter int PIN_W     = 32,
   parameter int PIN_COUNT = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIN_W-1:0]  pin_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [PIN_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [PIN_W-1:0]  rd_data,
   output logic              irq
);
   if (PIN_W < 1 || PIN_W > 32) begin : g_bad_width
      $error("PIN_W must lie in 1..32");
   end
   if (PIN_COUNT < 1 || PIN_COUNT > PIN_W) begin : g_bad_count
      $error("PIN_COUNT must lie in 1..PIN_W");
   end

   logic [PIN_W-1:0] rise_en, fall_en, evt_mask, clr_vec;
   logic [PIN_W-1:0] hit, cause_q, pending;

   evt_cfg_regs #(.PIN_W(PIN_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rise_en  (rise_en),
      .fall_en  (fall_en),
      .evt_mask (evt_mask),
      .clr_vec  (clr_vec)
   );

   evt_edge_detect #(.PIN_W(PIN_W), .PIN_COUNT(PIN_COUNT)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (pin_in),
      .rise_en (rise_en),
      .fall_en (fall_en),
      .hit     (hit)
   );

   evt_cause_store #(.PIN_W(PIN_W)) u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .clr_vec (clr_vec),
      .cause_q (cause_q)
   );

   assign pending = cause_q & evt_mask;
   assign irq     = |pending;

   always_comb begin
      unique case (rd_addr)
         EVT_RISE_EN: rd_data = rise_en;
         EVT_FALL_EN: rd_data = fall_en;
         EVT_MASK:    rd_data = evt_mask;
         EVT_PEND:    rd_data = pending;
         default:     rd_data = '0;
      endcase
   end
endmodule

// File: rtl/gpio_edge_cause_chk.sv
module gpio_edge_cause_chk #(
   parameter int PIN_W     = 32,
   parameter int PIN_COUNT = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PIN_W-1:0] pin_in,
   input logic             wr_en,
   input logic [2:0]       wr_addr,
   input logic [PIN_W-1:0] wr_data,
   input logic [PIN_W-1:0] rise_en,
   input logic [PIN_W-1:0] fall_en,
   input logic [PIN_W-1:0] mask,
   input logic [PIN_W-1:0] cause,
   input logic             irq
);
   localparam logic [PIN_W-1:0] LIVE = {PIN_W{1'b1}} >> (PIN_W - PIN_COUNT);

   logic [PIN_W-1:0] seen_q, edge_v, clr_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= '0;
      else        seen_q <= pin_in;
   end

   assign edge_v = LIVE & ((rise_en & pin_in & ~seen_q) | (fall_en & ~pin_in & seen_q));
   assign clr_v  = (wr_en && wr_addr == 3'd4) ? wr_data : '0;

   // R2 and R3: an enabled edge is captured on the next clock
   a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_v != '0) |=> ((cause & $past(edge_v)) == $past(edge_v)));

   // R3: no cause appears without an enabled edge
   a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause & ~$past(cause) & ~$past(edge_v)) == '0));

   // R4: causes drop only through a clear
   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(cause) & ~$past(clr_v) & ~cause) == '0));

   // R6: cleared bits without a coincident edge are gone
   a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(clr_v & ~edge_v) & cause) == '0));

   // R8: with everything masked the line stays low
   a_r8_quiet_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq);

   // R9: unwired pins hold no cause
   a_r9_dead_pins: assert property (@(posedge clk) disable iff (!rst_n)
      ((cause & ~LIVE) == '0));
endmodule

bind gpio_edge_cause_unit gpio_edge_cause_chk #(.PIN_W(PIN_W), .PIN_COUNT(PIN_COUNT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pin_in  (pin_in),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .rise_en (rise_en),
   .fall_en (fall_en),
   .mask    (evt_mask),
   .cause   (cause_q),
   .irq     (irq)
);

// File: tb/gpio_edge_cause_unit_tb.sv
`timescale 1ns/1ps
module gpio_edge_cause_unit_tb;
   localparam int W = 32;
   localparam int N = 28;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] pins = '0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [2:0]   rd_addr = '0;
   logic [W-1:0] rd_data;
   logic         irq;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   gpio_edge_cause_unit #(.PIN_W(W), .PIN_COUNT(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pins), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic clear_all();
      wr(3'd4, '1);
      pins = '0; tick();
   endtask

   task automatic t_reset();
      logic [W-1:0] v;
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), v);
         check("R1 reset read", v, '0);
      end
      check("R1 reset irq", W'(irq), '0);
   endtask

   task automatic t_map();
      logic [W-1:0] v;
      wr(3'd0, 32'h1234_5678); rd(3'd0, v); check("R10 rise readback", v, 32'h1234_5678);
      wr(3'd1, 32'h0F0F_0F0F); rd(3'd1, v); check("R10 fall readback", v, 32'h0F0F_0F0F);
      wr(3'd2, 32'hA5A5_A5A5); rd(3'd2, v); check("R10 mask readback", v, 32'hA5A5_A5A5);
      wr(3'd3, '1); wr(3'd5, '1); wr(3'd7, '1);
      rd(3'd0, v); check("R10 ignored writes", v, 32'h1234_5678);
      rd(3'd3, v); check("R10 pend untouched", v, '0);
      rd(3'd4, v); check("R10 clear reads 0", v, '0);
      wr(3'd0, '0); wr(3'd1, '0); wr(3'd2, '1);
   endtask

   task automatic t_rise();
      logic [W-1:0] v;
      wr(3'd0, 32'h8);
      pins[3] = 1'b1; tick();
      rd(3'd3, v); check("R2 rise sets", v, 32'h8);
      check("R8 irq on", W'(irq), 1);
      wr(3'd4, 32'h8);
      pins[3] = 1'b0; tick();
      rd(3'd3, v); check("R3 fall ignored when only rise", v, '0);
      check("R8 irq off", W'(irq), 0);
      wr(3'd0, '0);
   endtask

   task automatic t_fall_both_none();
      logic [W-1:0] v;
      pins[5] = 1'b1; pins[7] = 1'b1; pins[9] = 1'b1; tick();
      wr(3'd1, 32'h0A0); wr(3'd0, 32'h080);
      pins[5] = 1'b0; pins[9] = 1'b0; tick();
      rd(3'd3, v); check("R3 fall sets, none ignored", v, 32'h020);
      clear_all();
      pins[7] = 1'b0; tick();
      rd(3'd3, v); check("R3 both: fall", v, 32'h080);
      wr(3'd4, 32'h080);
      pins[7] = 1'b1; tick();
      rd(3'd3, v); check("R3 both: rise", v, 32'h080);
      wr(3'd0, '0); wr(3'd1, '0); clear_all();
   endtask

   task automatic t_sticky_mask();
      logic [W-1:0] v;
      wr(3'd2, '0); wr(3'd0, 32'h4);
      pins[2] = 1'b1; tick();
      rd(3'd3, v); check("R5 masked pending", v, '0);
      check("R8 masked irq low", W'(irq), 0);
      repeat (3) tick();
      wr(3'd2, 32'h4);
      rd(3'd3, v); check("R4 sticky exposed", v, 32'h4);
      check("R4 irq after unmask", W'(irq), 1);
      wr(3'd2, '1); wr(3'd0, '0); clear_all();
   endtask

   task automatic t_w1c();
      logic [W-1:0] v;
      wr(3'd0, 32'h3);
      pins[1:0] = 2'b11; tick();
      rd(3'd3, v); check("R2 two pins together", v, 32'h3);
      wr(3'd4, '0);
      rd(3'd3, v); check("R6 zero write no effect", v, 32'h3);
      wr(3'd4, 32'h1);
      rd(3'd3, v); check("R6 clears only bit 0", v, 32'h2);
      wr(3'd4, v);
      rd(3'd3, v); check("R6 write-back clears", v, '0);
      wr(3'd0, '0); clear_all();
   endtask

   task automatic t_set_wins();
      logic [W-1:0] v;
      wr(3'd0, 32'h10);
      pins[4] = 1'b1; tick();
      pins[4] = 1'b0; tick();
      wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h10; pins[4] = 1'b1;
      tick();
      wr_en = 1'b0;
      rd(3'd3, v); check("R7 set beats clear", v, 32'h10);
      wr(3'd0, '0); clear_all();
   endtask

   task automatic t_dead();
      logic [W-1:0] v;
      wr(3'd0, '1); wr(3'd1, '1);
      pins[30] = 1'b1; pins[28] = 1'b1; tick();
      pins[30] = 1'b0; tick();
      rd(3'd3, v); check("R9 dead pins", v, '0);
      check("R9 irq low", W'(irq), 0);
      wr(3'd0, '0); wr(3'd1, '0); clear_all();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_map();
      t_rise();
      t_fall_both_none();
      t_sticky_mask();
      t_w1c();
      t_set_wins();
      t_dead();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule